// File: doc/BRIEF.md
# Boot Strap Capture and Dual-Role Pin Controller

This block sits between a chip's active-low power-on reset pad and three dual-role pins. While the reset pad is low, the pins act as configuration inputs. On the clock edge where the synchronised reset releases, the block captures their levels once. Two of the captured bits set the rate plan for the rest of the chip. One selects the input reference rate (8 kHz or 25 MHz). The other selects the output clock rate (125 MHz or 156.25 MHz). The third captured bit is a factory test enable.

After capture, the same three pins become status outputs. The tri-state enables stay off for one clock cycle after capture, which gives external pull resistors time to release the nets. From the next edge the pins drive the tracking flag, the loss-of-lock flag and the input-one-valid flag. A cycle counter then marks the chip ready once the configuration period has elapsed. The reset pad clears everything asynchronously at any time, and the rest of the chip receives a synchronised copy of that reset.

Top module: `strap_boot_ctrl`

## Requirements
- R1: While `rst_n_pad` is low, the following outputs are all 0: `rst_n_sync`, `ready`, every `*_oe`, every `*_out`, `in_rate_hi`, `out_rate_hi` and `test_mode`. They go to 0 without waiting for a clock edge.
- R2: `rst_n_sync` rises on the second rising `clk` edge after `rst_n_pad` goes high. It stays high until the pad goes low again.
- R3: The pin levels present at the edge on which `rst_n_sync` rises are captured. After capture, `in_rate_hi` equals captured `cfg1_in` (1 = 25 MHz inputs, 0 = 8 kHz inputs). `out_rate_hi` equals captured `cfg0_in` (1 = 156.25 MHz outputs, 0 = 125 MHz outputs). `test_mode` equals captured `tst_in` (1 = test mode).
- R4: Later changes on `cfg0_in`, `cfg1_in` and `tst_in` have no effect on the three decoded outputs until the next reset.
- R5: All three output enables stay 0 until the third rising edge after pad release, which is one edge after capture. From that edge on, all three are 1.
- R6: While the enables are on, each data output shows the status input registered at the previous rising edge. `cfg0_out` shows `trk_stat`, `cfg1_out` shows `lol_stat`, and `tst_out` shows `ic1_ok_stat`.
- R7: A data output is 0 whenever its enable is 0.
- R8: `ready` rises on rising edge number 2 + READY_CYCLES after pad release, counting the first edge after release as 1. It stays high until the next reset.
- R9: Pulling `rst_n_pad` low during operation clears the enables, `ready`, `rst_n_sync` and the decoded outputs at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n_pad | input | 1 | Active-low reset from the pad, asynchronous |
| cfg0_in | input | 1 | Pad input level, output-rate strap |
| cfg1_in | input | 1 | Pad input level, input-rate strap |
| tst_in | input | 1 | Pad input level, test-enable strap |
| trk_stat | input | 1 | Tracking flag to be driven on pin 0 |
| lol_stat | input | 1 | Loss-of-lock flag to be driven on pin 1 |
| ic1_ok_stat | input | 1 | Input-one-valid flag to be driven on pin 2 |
| cfg0_out | output | 1 | Pad drive value, pin 0 |
| cfg0_oe | output | 1 | Pad output enable, pin 0 |
| cfg1_out | output | 1 | Pad drive value, pin 1 |
| cfg1_oe | output | 1 | Pad output enable, pin 1 |
| tst_out | output | 1 | Pad drive value, pin 2 |
| tst_oe | output | 1 | Pad output enable, pin 2 |
| in_rate_hi | output | 1 | 1 = 25 MHz inputs, 0 = 8 kHz inputs |
| out_rate_hi | output | 1 | 1 = 156.25 MHz outputs, 0 = 125 MHz outputs |
| test_mode | output | 1 | Captured test enable |
| rst_n_sync | output | 1 | Synchronised active-low reset for the chip |
| ready | output | 1 | Configuration period complete |

## Verification
Number the rising edges after pad release starting from 1. The synchronised reset and the decoded straps are due after edge 2, the enables after edge 3, and ready after edge 2 + READY_CYCLES. Each status value appears on the pins one edge after it is applied. The bench changes inputs and samples outputs only at falling edges, and it counts falling edges from the release so that each check falls in the first half-cycle in which its result is due. The one checked edge just before each deadline confirms that nothing arrives early. The asynchronous clear is checked 1 ns after the pad falls, well before the next rising edge.

// File: rtl/strap_boot_pkg.sv
package strap_boot_pkg;

    // Pin slots shared by the strap inputs and the status outputs.
    localparam int PIN_CNT  = 3;
    localparam int PIN_ORATE = 0;  // strap: output rate, later tracking flag
    localparam int PIN_IRATE = 1;  // strap: input rate, later loss-of-lock flag
    localparam int PIN_TEST  = 2;  // strap: test enable, later input-one-valid

    typedef enum logic {
        IN_RATE_8K  = 1'b0,
        IN_RATE_25M = 1'b1
    } in_rate_e;

    typedef enum logic {
        OUT_RATE_125M = 1'b0,
        OUT_RATE_156M = 1'b1
    } out_rate_e;

    typedef struct packed {
        logic      test_en;
        out_rate_e out_rate;
        in_rate_e  in_rate;
    } strap_cfg_t;

    function automatic strap_cfg_t decode_straps(input logic [PIN_CNT-1:0] raw);
        strap_cfg_t c;
        c.in_rate  = raw[PIN_IRATE] ? IN_RATE_25M : IN_RATE_8K;
        c.out_rate = raw[PIN_ORATE] ? OUT_RATE_156M : OUT_RATE_125M;
        c.test_en  = raw[PIN_TEST];
        return c;
    endfunction

endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_pad,
    output logic rst_n_sync,
    output logic release_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n_pad) begin
        if (!rst_n_pad) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_sync    = st_q.chain[STAGES-1];
    // High during the cycle whose closing edge releases the synchronised reset.
    assign release_pulse = st_q.chain[STAGES-2] & ~st_q.chain[STAGES-1];
endmodule

// File: rtl/sb_strap_latch.sv
module sb_strap_latch
    import strap_boot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n_pad,
    input  logic               capture,
    input  logic [PIN_CNT-1:0] pin_in,
    output strap_cfg_t         cfg
);
    typedef struct packed {
        logic [PIN_CNT-1:0] raw;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.raw = pin_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n_pad) begin
        if (!rst_n_pad) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = decode_straps(st_q.raw);
endmodule

// File: rtl/sb_pin_ctrl.sv
module sb_pin_ctrl
    import strap_boot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_CNT-1:0] stat_in,
    output logic [PIN_CNT-1:0] pin_out,
    output logic [PIN_CNT-1:0] pin_oe
);
    typedef struct packed {
        logic               drive;
        logic [PIN_CNT-1:0] stat;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // First enabled edge turns the drivers on; the cycle before it is the gap.
        st_d.drive = 1'b1;
        st_d.stat  = stat_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
        assign pin_oe[g]  = st_q.drive;
        assign pin_out[g] = st_q.drive & st_q.stat[g];
    end
endmodule

// File: rtl/sb_ready_timer.sv
module sb_ready_timer #(
    parameter int READY_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CNT_W = $clog2(READY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(READY_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.done;
endmodule

// File: rtl/strap_boot_ctrl.sv
module strap_boot_ctrl
    import strap_boot_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int READY_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n_pad,
    input  logic cfg0_in,
    input  logic cfg1_in,
    input  logic tst_in,
    input  logic trk_stat,
    input  logic lol_stat,
    input  logic ic1_ok_stat,
    output logic cfg0_out,
    output logic cfg0_oe,
    output logic cfg1_out,
    output logic cfg1_oe,
    output logic tst_out,
    output logic tst_oe,
    output logic in_rate_hi,
    output logic out_rate_hi,
    output logic test_mode,
    output logic rst_n_sync,
    output logic ready
);
    logic               rel_pulse;
    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] stat_vec;
    logic [PIN_CNT-1:0] drv_val;
    logic [PIN_CNT-1:0] drv_en;
    strap_cfg_t         cfg;

    assign pins_raw[PIN_ORATE] = cfg0_in;
    assign pins_raw[PIN_IRATE] = cfg1_in;
    assign pins_raw[PIN_TEST]  = tst_in;

    assign stat_vec[PIN_ORATE] = trk_stat;
    assign stat_vec[PIN_IRATE] = lol_stat;
    assign stat_vec[PIN_TEST]  = ic1_ok_stat;

    sb_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk           (clk),
        .rst_n_pad     (rst_n_pad),
        .rst_n_sync    (rst_n_sync),
        .release_pulse (rel_pulse)
    );

    sb_strap_latch u_latch (
        .clk       (clk),
        .rst_n_pad (rst_n_pad),
        .capture   (rel_pulse),
        .pin_in    (pins_raw),
        .cfg       (cfg)
    );

    sb_pin_ctrl u_pins (
        .clk     (clk),
        .rst_n   (rst_n_sync),
        .stat_in (stat_vec),
        .pin_out (drv_val),
        .pin_oe  (drv_en)
    );

    sb_ready_timer #(.READY_CYCLES(READY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .ready (ready)
    );

    assign in_rate_hi  = (cfg.in_rate == IN_RATE_25M);
    assign out_rate_hi = (cfg.out_rate == OUT_RATE_156M);
    assign test_mode   = cfg.test_en;

    assign cfg0_out = drv_val[PIN_ORATE];
    assign cfg1_out = drv_val[PIN_IRATE];
    assign tst_out  = drv_val[PIN_TEST];
    assign cfg0_oe  = drv_en[PIN_ORATE];
    assign cfg1_oe  = drv_en[PIN_IRATE];
    assign tst_oe   = drv_en[PIN_TEST];
endmodule

// File: rtl/sb_checker.sv
module sb_checker (
    input logic clk,
    input logic rst_n_pad,
    input logic rst_n_sync,
    input logic cfg0_out,
    input logic cfg1_out,
    input logic tst_out,
    input logic cfg0_oe,
    input logic cfg1_oe,
    input logic tst_oe,
    input logic in_rate_hi,
    input logic out_rate_hi,
    input logic test_mode,
    input logic ready
);
    logic [2:0] oe_v;
    logic [2:0] out_v;
    logic [2:0] cfg_v;

    assign oe_v  = {tst_oe, cfg1_oe, cfg0_oe};
    assign out_v = {tst_out, cfg1_out, cfg0_out};
    assign cfg_v = {test_mode, out_rate_hi, in_rate_hi};

    // R1
    always @(posedge clk) begin
        if (rst_n_pad === 1'b0) begin
            reset_quiet_chk: assert (oe_v == 3'b000 && !ready && !rst_n_sync && cfg_v == 3'b000);
        end
    end

    // R2
    sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n_pad)
        $rose(rst_n_sync) |-> $past(rst_n_pad, 2));

    // R4
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
        $past(rst_n_sync) |-> $stable(cfg_v));

    // R5
    oe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
        !$past(rst_n_sync) |-> oe_v == 3'b000);

    // R5
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
        $past(rst_n_sync) |-> oe_v == 3'b111);

    // R7
    always @(posedge clk) begin
        if (rst_n_pad === 1'b1) begin
            idle_low_chk: assert ((out_v & ~oe_v) == 3'b000);
        end
    end

    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
        ready |=> ready);

    // R8
    ready_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
        ready |-> oe_v == 3'b111);
endmodule

bind strap_boot_ctrl sb_checker u_sb_chk (
    .clk         (clk),
    .rst_n_pad   (rst_n_pad),
    .rst_n_sync  (rst_n_sync),
    .cfg0_out    (cfg0_out),
    .cfg1_out    (cfg1_out),
    .tst_out     (tst_out),
    .cfg0_oe     (cfg0_oe),
    .cfg1_oe     (cfg1_oe),
    .tst_oe      (tst_oe),
    .in_rate_hi  (in_rate_hi),
    .out_rate_hi (out_rate_hi),
    .test_mode   (test_mode),
    .ready       (ready)
);

// File: tb/strap_boot_ctrl_bench.sv
`timescale 1ns/1ps
module strap_boot_ctrl_bench;
    localparam int N_RDY = 20;

    logic clk = 1'b0;
    logic rst_n_pad, cfg0_in, cfg1_in, tst_in, trk_stat, lol_stat, ic1_ok_stat;
    logic cfg0_out, cfg0_oe, cfg1_out, cfg1_oe, tst_out, tst_oe;
    logic in_rate_hi, out_rate_hi, test_mode, rst_n_sync, ready;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    strap_boot_ctrl #(.SYNC_STAGES(2), .READY_CYCLES(N_RDY)) u_strap_boot_ctrl (
        .clk(clk), .rst_n_pad(rst_n_pad),
        .cfg0_in(cfg0_in), .cfg1_in(cfg1_in), .tst_in(tst_in),
        .trk_stat(trk_stat), .lol_stat(lol_stat), .ic1_ok_stat(ic1_ok_stat),
        .cfg0_out(cfg0_out), .cfg0_oe(cfg0_oe), .cfg1_out(cfg1_out), .cfg1_oe(cfg1_oe),
        .tst_out(tst_out), .tst_oe(tst_oe),
        .in_rate_hi(in_rate_hi), .out_rate_hi(out_rate_hi), .test_mode(test_mode),
        .rst_n_sync(rst_n_sync), .ready(ready)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] oes();
        return {5'b0, tst_oe, cfg1_oe, cfg0_oe};
    endfunction
    function automatic logic [7:0] outs();
        return {5'b0, tst_out, cfg1_out, cfg0_out};
    endfunction
    function automatic logic [7:0] dec();
        return {5'b0, test_mode, out_rate_hi, in_rate_hi};
    endfunction

    // Strap bits s: bit0 = cfg0_in, bit1 = cfg1_in, bit2 = tst_in.
    task automatic set_pins(input logic [2:0] s);
        cfg0_in = s[0]; cfg1_in = s[1]; tst_in = s[2];
    endtask
    task automatic set_stat(input logic [2:0] t);
        trk_stat = t[0]; lol_stat = t[1]; ic1_ok_stat = t[2];
    endtask

    initial begin
        rst_n_pad = 1'b0;
        set_pins(3'b000);
        set_stat(3'b111);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 oe", oes(), 8'h00);
        check("R1 outs", outs(), 8'h00);
        check("R1 ready/sync", {6'b0, ready, rst_n_sync}, 8'h00);
        check("R1 decoded", dec(), 8'h00);

        for (int s = 0; s < 8; s++) begin
            logic [2:0] sv;
            sv = 3'(s);
            @(negedge clk);
            rst_n_pad = 1'b0;
            set_pins(sv);
            set_stat(3'b111);
            repeat (2) @(negedge clk);
            check("R1 oe in reset", oes(), 8'h00);
            check("R1 decoded in reset", dec(), 8'h00);
            rst_n_pad = 1'b1;
            @(negedge clk); // after edge 1
            check("R2 sync low after edge 1", {7'b0, rst_n_sync}, 8'h00);
            @(negedge clk); // after edge 2
            check("R2 sync high after edge 2", {7'b0, rst_n_sync}, 8'h01);
            check("R3 decoded straps", dec(), {5'b0, sv[2], sv[0], sv[1]});
            check("R5 oe gap", oes(), 8'h00);
            check("R7 outs zero while disabled", outs(), 8'h00);
            set_pins(~sv);
            set_stat(sv);
            @(negedge clk); // after edge 3
            check("R5 oe on", oes(), 8'h07);
            check("R6 status mapping", outs(), {5'b0, sv});
            for (int t = 0; t < 8; t++) begin
                set_stat(3'(t));
                @(negedge clk); // edges 4..11
                check("R6 status sweep", outs(), 8'(t));
            end
            check("R4 straps ignored after capture", dec(), {5'b0, sv[2], sv[0], sv[1]});
            repeat (N_RDY + 1 - 11) @(negedge clk);
            check("R8 ready not early", {7'b0, ready}, 8'h00);
            @(negedge clk);
            check("R8 ready due", {7'b0, ready}, 8'h01);
            @(negedge clk);
            check("R8 ready held", {7'b0, ready}, 8'h01);
            check("R4 straps still held", dec(), {5'b0, sv[2], sv[0], sv[1]});
            #1;
            rst_n_pad = 1'b0;
            #1;
            check("R9 async clear oe", oes(), 8'h00);
            check("R9 async clear ready/sync", {6'b0, ready, rst_n_sync}, 8'h00);
            check("R9 async clear decoded", dec(), 8'h00);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule